// File: doc/BRIEF.md
# Transmit Buffer Arbiter with Preemptive Drop

This block decides which of several transmit buffers is offered to a CAN protocol engine, and what happens to a frame after a failed attempt. Software marks a buffer as ready through a one-cycle command. Each buffer presents its identifier and a format flag (base or extended). While the engine is idle, the arbiter picks the ready buffer that would win bus arbitration and hands its index to the engine. It then waits for one of three outcome strobes: success, lost arbitration or error.

After lost arbitration or an error, the arbiter has three possible actions:
- retry the same buffer and advance a retry counter;
- give the buffer up as failed, when an optional retry limit has been reached;
- when drop mode is on, set the current frame aside in favour of a waiting frame with higher priority.

A buffer that was set aside keeps competing for the bus. Each buffer shows its state on a status port. A single interrupt line pulses for one cycle whenever any status changes.

Top module: `tx_arbiter_top`

## Requirements
- R1: While reset is held and after it is released, every buffer status reads EMPTY (code 0), `tx_valid` is 0, `retry_cnt` is 0 and `irq` is 0. The status codes are EMPTY=0, READY=1, TXING=2, DONE=3, FAILED=4, DROPPED=5. Buffer i uses status bits [3i+2:3i].
- R2: A pulse on `cmd_ready[i]` moves buffer i to READY at the next edge only if the buffer is EMPTY, DONE or FAILED. In READY, TXING or DROPPED the pulse has no effect.
- R3: When no frame is in progress and at least one buffer is READY or DROPPED, the arbiter selects one at the next edge. That buffer becomes TXING, `tx_valid` becomes 1 and `tx_idx` becomes its index.
  - The selected buffer has the smallest priority key.
  - A base identifier sits in `buf_id` bits [10:0]. An extended identifier uses bits [28:0], and its bits [28:18] are compared against the base identifier.
  - When these 11-bit values are equal, a base frame beats an extended frame. After that, the lower extended bits [17:0] win.
  - When two keys are fully equal, the lower index wins.
- R4: `eng_ok` while `tx_valid` is 1 moves the current buffer to DONE, drops `tx_valid` and clears `retry_cnt` at the next edge. `eng_ok` takes precedence over the failure strobes.
- R5: A failure (`eng_arb_lost` or `eng_err`) while `tx_valid` is 1 keeps the same buffer TXING and adds one to `retry_cnt`, saturating at its maximum. This applies when neither R6 nor R8 applies.
- R6: A failure while `cfg_limit_en` is 1 and `retry_cnt` equals `cfg_limit` has three effects at the next edge: the buffer becomes FAILED, `tx_valid` drops and `retry_cnt` clears. This check has precedence over R8.
- R7: While `cfg_limit_en` is 0, no number of failures makes a buffer FAILED.
- R8: A failure while `cfg_drop_en` is 1, with a READY or DROPPED buffer whose key is strictly smaller than the current one, has three effects at the same edge:
  - the current buffer becomes DROPPED;
  - the best such buffer becomes TXING and is shown on `tx_idx`;
  - `retry_cnt` clears.
- R9: A DROPPED buffer competes in selection exactly like a READY buffer.
- R10: `irq` is 1 for exactly the cycles in which the status port differs from its value in the previous cycle.
- R11: Outcome strobes while `tx_valid` is 0 change no status and leave `retry_cnt` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_ready | input | NBUF | Per-buffer pulse marking a buffer ready |
| buf_id | input | NBUF*ID_W | Identifier of each buffer, buffer i at bits [i*ID_W +: ID_W] |
| buf_ext | input | NBUF | 1 = extended identifier format |
| cfg_drop_en | input | 1 | Enable preemptive drop on failure |
| cfg_limit_en | input | 1 | Enable the retry limit |
| cfg_limit | input | CNT_W | Retries allowed before failure |
| eng_ok | input | 1 | Engine reports a frame sent |
| eng_arb_lost | input | 1 | Engine reports lost arbitration |
| eng_err | input | 1 | Engine reports an error |
| tx_valid | output | 1 | A buffer is handed to the engine |
| tx_idx | output | IDX_W | Index of the handed buffer |
| retry_cnt | output | CNT_W | Retries of the current frame |
| buf_status | output | NBUF*3 | Status code of each buffer |
| irq | output | 1 | One-cycle pulse on any status change |

## Verification
The hardest situation to reach is a failure that falls on the same edge as two other conditions. The first is a better-ranked buffer waiting in READY or DROPPED. The second is the retry limit being reached or just missed. Only that combination separates the precedence of R6 over R8.

Directed sequences create it deliberately. They load a lower identifier while a frame is in flight and then raise a failure strobe. Long random runs then switch the drop and limit settings per segment, with small limits, so these collisions recur many times. A bench reference model predicts every status and the counter on every cycle.

// File: rtl/tx_arb_pkg.sv
package tx_arb_pkg;
   typedef enum logic [2:0] {
      ST_EMPTY   = 3'd0,
      ST_READY   = 3'd1,
      ST_TXING   = 3'd2,
      ST_DONE    = 3'd3,
      ST_FAILED  = 3'd4,
      ST_DROPPED = 3'd5
   } buf_state_e;

   localparam int BASE_W = 11;
   localparam int STAT_W = 3;

   function automatic logic is_eligible(buf_state_e s);
      return (s == ST_READY) || (s == ST_DROPPED);
   endfunction

   function automatic logic accepts_cmd(buf_state_e s);
      return (s == ST_EMPTY) || (s == ST_DONE) || (s == ST_FAILED);
   endfunction
endpackage

// File: rtl/tx_prio_key.sv
module tx_prio_key #(
   parameter int ID_W = 29
) (
   input  logic [ID_W-1:0] id,
   input  logic            ext,
   output logic [ID_W:0]   key
);
   localparam int BW = tx_arb_pkg::BASE_W;
   localparam int LW = ID_W - BW;

   logic [BW-1:0] head;
   logic [LW-1:0] tail;

   always_comb begin
      if (ext) begin
         head = id[ID_W-1 -: BW];
         tail = id[LW-1:0];
      end else begin
         head = id[BW-1:0];
         tail = '0;
      end
      key = {head, ext, tail};
   end
endmodule

// File: rtl/tx_prio_pick.sv
module tx_prio_pick #(
   parameter int NBUF  = 4,
   parameter int KEY_W = 30,
   parameter int IDX_W = 2
) (
   input  logic [NBUF-1:0]       cand,
   input  logic [NBUF*KEY_W-1:0] keys,
   output logic                  found,
   output logic [IDX_W-1:0]      idx,
   output logic [KEY_W-1:0]      best_key
);
   always_comb begin
      found    = 1'b0;
      idx      = '0;
      best_key = '1;
      for (int i = 0; i < NBUF; i++) begin
         if (cand[i] && (!found || (keys[i*KEY_W +: KEY_W] < best_key))) begin
            found    = 1'b1;
            idx      = IDX_W'(i);
            best_key = keys[i*KEY_W +: KEY_W];
         end
      end
   end
endmodule

// File: rtl/tx_retry_ctr.sv
module tx_retry_ctr #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (inc && (cnt != CNT_MAX))
         cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/tx_arbiter_top.sv
module tx_arbiter_top #(
   parameter int NBUF          = 4,
   parameter int ID_W          = 29,
   parameter int CNT_W         = 4,
   parameter bit LIMIT_SUPPORT = 1'b1,
   localparam int IDX_W        = (NBUF > 1) ? $clog2(NBUF) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NBUF-1:0]      cmd_ready,
   input  logic [NBUF*ID_W-1:0] buf_id,
   input  logic [NBUF-1:0]      buf_ext,
   input  logic                 cfg_drop_en,
   input  logic                 cfg_limit_en,
   input  logic [CNT_W-1:0]     cfg_limit,
   input  logic                 eng_ok,
   input  logic                 eng_arb_lost,
   input  logic                 eng_err,
   output logic                 tx_valid,
   output logic [IDX_W-1:0]     tx_idx,
   output logic [CNT_W-1:0]     retry_cnt,
   output logic [NBUF*3-1:0]    buf_status,
   output logic                 irq
);
   import tx_arb_pkg::*;

   localparam int KEY_W = ID_W + 1;

   if (NBUF < 2) begin : g_bad_nbuf
      $error("tx_arbiter_top: NBUF must be at least 2");
   end
   if (ID_W < BASE_W + 1) begin : g_bad_idw
      $error("tx_arbiter_top: ID_W must exceed the base identifier width");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("tx_arbiter_top: CNT_W must be positive");
   end

   buf_state_e             st_q [NBUF];
   buf_state_e             st_d [NBUF];
   logic [NBUF-1:0]        elig;
   logic [NBUF-1:0]        chg;
   logic [NBUF*KEY_W-1:0]  keys;
   logic                   found;
   logic [IDX_W-1:0]       pick_idx;
   logic [KEY_W-1:0]       pick_key;
   logic [KEY_W-1:0]       cur_key;
   logic                   busy_q;
   logic [IDX_W-1:0]       cur_q;
   logic                   ok_ev;
   logic                   fail_ev;
   logic                   limit_hit;
   logic                   drop_go;
   logic                   start_go;
   logic                   cnt_clr;

   // Per-buffer priority keys
   for (genvar g = 0; g < NBUF; g++) begin : g_key
      tx_prio_key #(.ID_W(ID_W)) u_key (
         .id  (buf_id[g*ID_W +: ID_W]),
         .ext (buf_ext[g]),
         .key (keys[g*KEY_W +: KEY_W])
      );
      assign elig[g] = is_eligible(st_q[g]);
   end

   tx_prio_pick #(.NBUF(NBUF), .KEY_W(KEY_W), .IDX_W(IDX_W)) u_pick (
      .cand     (elig),
      .keys     (keys),
      .found    (found),
      .idx      (pick_idx),
      .best_key (pick_key)
   );

   always_comb begin
      cur_key = '1;
      for (int i = 0; i < NBUF; i++)
         if (cur_q == IDX_W'(i)) cur_key = keys[i*KEY_W +: KEY_W];
   end

   assign ok_ev    = busy_q & eng_ok;
   assign fail_ev  = busy_q & ~eng_ok & (eng_arb_lost | eng_err);

   // Retry limit: present or compiled out
   if (LIMIT_SUPPORT) begin : g_limit
      assign limit_hit = cfg_limit_en && (retry_cnt == cfg_limit);
   end else begin : g_nolimit
      logic unused_limit;
      assign unused_limit = cfg_limit_en ^ (^cfg_limit);
      assign limit_hit    = 1'b0;
   end

   assign drop_go  = fail_ev & ~limit_hit & cfg_drop_en & found & (pick_key < cur_key);
   assign start_go = ~busy_q & found;
   assign cnt_clr  = ok_ev | (fail_ev & limit_hit) | drop_go | ~busy_q;

   tx_retry_ctr #(.CNT_W(CNT_W)) u_retry (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .inc   (fail_ev),
      .cnt   (retry_cnt)
   );

   // Next status of each buffer
   for (genvar g = 0; g < NBUF; g++) begin : g_state
      logic is_cur;
      logic is_pick;
      assign is_cur  = busy_q && (cur_q == IDX_W'(g));
      assign is_pick = found && (pick_idx == IDX_W'(g));

      always_comb begin
         st_d[g] = st_q[g];
         if (is_cur && ok_ev)
            st_d[g] = ST_DONE;
         else if (is_cur && fail_ev && limit_hit)
            st_d[g] = ST_FAILED;
         else if (is_cur && drop_go)
            st_d[g] = ST_DROPPED;
         else if (is_pick && (drop_go || start_go))
            st_d[g] = ST_TXING;
         else if (cmd_ready[g] && accepts_cmd(st_q[g]))
            st_d[g] = ST_READY;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) st_q[g] <= ST_EMPTY;
         else        st_q[g] <= st_d[g];
      end

      assign chg[g] = (st_d[g] != st_q[g]);
      assign buf_status[g*STAT_W +: STAT_W] = st_q[g];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cur_q  <= '0;
         irq    <= 1'b0;
      end else begin
         irq <= |chg;
         if (ok_ev || (fail_ev && limit_hit)) begin
            busy_q <= 1'b0;
         end else if (drop_go || start_go) begin
            busy_q <= 1'b1;
            cur_q  <= pick_idx;
         end
      end
   end

   assign tx_valid = busy_q;
   assign tx_idx   = cur_q;
endmodule

// File: rtl/tx_arbiter_chk.sv
module tx_arbiter_chk #(
   parameter int NBUF  = 4,
   parameter int CNT_W = 4,
   parameter int IDX_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_limit_en,
   input logic [CNT_W-1:0]  cfg_limit,
   input logic              eng_ok,
   input logic              eng_arb_lost,
   input logic              eng_err,
   input logic              tx_valid,
   input logic [IDX_W-1:0]  tx_idx,
   input logic [CNT_W-1:0]  retry_cnt,
   input logic [NBUF*3-1:0] buf_status,
   input logic              irq
);
   logic [NBUF-1:0] txing;
   logic [NBUF-1:0] failed;
   for (genvar g = 0; g < NBUF; g++) begin : g_dec
      assign txing[g]  = (buf_status[g*3 +: 3] == 3'd2);
      assign failed[g] = (buf_status[g*3 +: 3] == 3'd4);
   end

   logic fail_in;
   assign fail_in = eng_arb_lost | eng_err;

   // R3 R8: at most one buffer in flight, and it agrees with tx_valid
   assert_single_txing_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($onehot0(txing) && (tx_valid == (|txing))));

   // R10: interrupt pulses exactly on a status change
   assert_irq_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (buf_status != $past(buf_status)));

   // R4: success finishes the frame
   assert_success_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && eng_ok) |=> (!tx_valid && retry_cnt == '0));

   // R6: reaching the limit fails the frame
   assert_limit_fail_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !eng_ok && fail_in && cfg_limit_en && retry_cnt == cfg_limit)
      |=> (!tx_valid && retry_cnt == '0 && $countones(failed) >= 1));

   // R7: with the limit off no buffer newly fails
   assert_no_fail_unlimited_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_limit_en) |=> ($countones(failed) <= $countones($past(failed))));

   // R11: the counter rests at zero while idle
   assert_idle_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_valid |-> retry_cnt == '0);
endmodule

bind tx_arbiter_top tx_arbiter_chk #(.NBUF(NBUF), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_limit_en (cfg_limit_en),
   .cfg_limit    (cfg_limit),
   .eng_ok       (eng_ok),
   .eng_arb_lost (eng_arb_lost),
   .eng_err      (eng_err),
   .tx_valid     (tx_valid),
   .tx_idx       (tx_idx),
   .retry_cnt    (retry_cnt),
   .buf_status   (buf_status),
   .irq          (irq)
);

// File: tb/sim_tx_arbiter_top.sv
module sim_tx_arbiter_top;
   localparam int CLK_PERIOD = 10;
   localparam int NB = 4;
   localparam int IW = 29;
   localparam int CW = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NB-1:0]  cmd_ready = '0;
   logic [IW-1:0]  ids [NB];
   logic [NB*IW-1:0] buf_id;
   logic [NB-1:0]  buf_ext = '0;
   logic           cfg_drop_en = 1'b0;
   logic           cfg_limit_en = 1'b0;
   logic [CW-1:0]  cfg_limit = '0;
   logic           eng_ok = 1'b0;
   logic           eng_arb_lost = 1'b0;
   logic           eng_err = 1'b0;
   logic           tx_valid;
   logic [1:0]     tx_idx;
   logic [CW-1:0]  retry_cnt;
   logic [NB*3-1:0] buf_status;
   logic           irq;

   int checks = 0;
   int errors = 0;

   // reference model state
   int m_st [NB];
   bit m_busy;
   int m_cur;
   int m_cnt;
   bit m_irq;

   always #(CLK_PERIOD/2) clk = ~clk;

   always_comb
      for (int i = 0; i < NB; i++) buf_id[i*IW +: IW] = ids[i];

   tx_arbiter_top u0 (
      .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .buf_id(buf_id), .buf_ext(buf_ext),
      .cfg_drop_en(cfg_drop_en), .cfg_limit_en(cfg_limit_en), .cfg_limit(cfg_limit),
      .eng_ok(eng_ok), .eng_arb_lost(eng_arb_lost), .eng_err(eng_err),
      .tx_valid(tx_valid), .tx_idx(tx_idx), .retry_cnt(retry_cnt),
      .buf_status(buf_status), .irq(irq)
   );

   function automatic logic [29:0] key_of(logic [IW-1:0] id, logic ext);
      if (ext) return {id[28:18], 1'b1, id[17:0]};
      return {id[10:0], 1'b0, 18'd0};
   endfunction

   function automatic int st_of(int i);
      return int'(buf_status[i*3 +: 3]);
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < NB; i++) m_st[i] = 0;
      m_busy = 0; m_cur = 0; m_cnt = 0; m_irq = 0;
   endtask

   task automatic model_step();
      int  n_st [NB];
      bit  found = 0;
      int  pick = 0;
      bit  ok_ev, fail_ev, hit, drop, start;
      for (int i = 0; i < NB; i++) begin
         n_st[i] = m_st[i];
         if ((m_st[i] == 1 || m_st[i] == 5) &&
             (!found || key_of(ids[i], buf_ext[i]) < key_of(ids[pick], buf_ext[pick]))) begin
            found = 1; pick = i;
         end
      end
      ok_ev   = m_busy && eng_ok;
      fail_ev = m_busy && !eng_ok && (eng_arb_lost || eng_err);
      hit     = cfg_limit_en && (m_cnt == int'(cfg_limit));
      drop    = fail_ev && !hit && cfg_drop_en && found &&
                (key_of(ids[pick], buf_ext[pick]) < key_of(ids[m_cur], buf_ext[m_cur]));
      start   = !m_busy && found;
      for (int i = 0; i < NB; i++) begin
         bit cur = m_busy && (m_cur == i);
         if (cur && ok_ev) n_st[i] = 3;
         else if (cur && fail_ev && hit) n_st[i] = 4;
         else if (cur && drop) n_st[i] = 5;
         else if (found && pick == i && (drop || start)) n_st[i] = 2;
         else if (cmd_ready[i] && (m_st[i] == 0 || m_st[i] == 3 || m_st[i] == 4)) n_st[i] = 1;
      end
      if (ok_ev || (fail_ev && hit) || drop || !m_busy) m_cnt = 0;
      else if (fail_ev && m_cnt < 15) m_cnt++;
      if (ok_ev || (fail_ev && hit)) m_busy = 0;
      else if (drop || start) begin m_busy = 1; m_cur = pick; end
      m_irq = 0;
      for (int i = 0; i < NB; i++) begin
         if (n_st[i] != m_st[i]) m_irq = 1;
         m_st[i] = n_st[i];
      end
   endtask

   task automatic compare(input string tag);
      for (int i = 0; i < NB; i++) chk({tag, " status"}, st_of(i), m_st[i]);
      chk({tag, " tx_valid"}, int'(tx_valid), int'(m_busy));
      if (m_busy) chk({tag, " tx_idx"}, int'(tx_idx), m_cur);
      chk({tag, " retry_cnt"}, int'(retry_cnt), m_cnt);
      chk({tag, " irq R10"}, int'(irq), int'(m_irq));
   endtask

   task automatic step(input string tag);
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare(tag);
      cmd_ready = '0; eng_ok = 0; eng_arb_lost = 0; eng_err = 0;
   endtask

   task automatic load(input int b, input logic [IW-1:0] id, input logic ext);
      ids[b] = id; buf_ext[b] = ext; cmd_ready[b] = 1'b1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < NB; i++) ids[i] = '0;
      model_reset();
      repeat (3) @(negedge clk);
      chk("R1 status in reset", int'(buf_status), 0);
      chk("R1 tx_valid in reset", int'(tx_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1 after reset");
      chk("R1 irq after reset", int'(irq), 0);

      // R2, R3: base wins tie with extended of same top bits
      load(0, (29'd5 << 18) | 29'd3, 1'b1);
      load(1, 29'd5, 1'b0);
      load(2, 29'd7, 1'b0);
      step("R2 load");
      chk("R2 buf1 ready", st_of(1), 1);
      step("R3 select");
      chk("R3 tie base wins idx", int'(tx_idx), 1);
      chk("R10 irq on select", int'(irq), 1);
      eng_arb_lost = 1;
      step("R5 retry");
      chk("R5 retry count", int'(retry_cnt), 1);
      chk("R5 same buffer", st_of(1), 2);
      eng_ok = 1;
      step("R4 done");
      chk("R4 buf1 done", st_of(1), 3);
      chk("R4 tx_valid low", int'(tx_valid), 0);
      step("R3 next select");
      chk("R3 ext top bits rank", int'(tx_idx), 0);
      cmd_ready[0] = 1'b1;
      step("R2 ignore");
      chk("R2 txing buffer ignores cmd", st_of(0), 2);
      // R8: drop in favour of better buffer
      cfg_drop_en = 1;
      load(1, 29'd1, 1'b0);
      step("R2 reload");
      eng_err = 1;
      step("R8 drop");
      chk("R8 dropped", st_of(0), 5);
      chk("R8 new idx", int'(tx_idx), 1);
      chk("R8 count clear", int'(retry_cnt), 0);
      cmd_ready[0] = 1'b1;
      eng_ok = 1;
      step("R4 done2");
      chk("R2 dropped ignores cmd", st_of(0), 5);
      step("R9 select");
      chk("R9 dropped competes", int'(tx_idx), 0);
      // R6: limit 2
      cfg_drop_en = 0; cfg_limit_en = 1; cfg_limit = 4'd2;
      for (int k = 0; k < 3; k++) begin
         eng_arb_lost = 1;
         step("R6 fail loop");
      end
      chk("R6 failed", st_of(0), 4);
      chk("R6 idle", int'(tx_valid), 0);
      chk("R6 count clear", int'(retry_cnt), 0);
      step("R3 after fail");
      chk("R3 pick buf2", int'(tx_idx), 2);
      // R7: unlimited
      cfg_limit_en = 0;
      for (int k = 0; k < 20; k++) begin
         eng_err = 1;
         step("R7 loop");
      end
      chk("R7 still txing", st_of(2), 2);
      chk("R5 saturated", int'(retry_cnt), 15);
      eng_ok = 1;
      step("R4 done3");
      // R11: strobes while idle
      eng_err = 1; eng_arb_lost = 1;
      step("R11 idle strobe");
      eng_ok = 1;
      step("R11 idle ok");
      chk("R11 buf2 stays done", st_of(2), 3);
      chk("R11 count zero", int'(retry_cnt), 0);
      chk("R10 no change no irq", int'(irq), 0);

      // random phase
      void'($urandom(32'd1234));
      for (int seg = 0; seg < 40; seg++) begin
         cfg_drop_en  = $urandom % 2;
         cfg_limit_en = $urandom % 2;
         cfg_limit    = CW'($urandom % 4);
         for (int c = 0; c < 100; c++) begin
            for (int b = 0; b < NB; b++) begin
               if (($urandom % 6) == 0) begin
                  if (m_st[b] == 0 || m_st[b] == 3 || m_st[b] == 4) begin
                     ids[b] = ($urandom % 3 == 0) ? IW'($urandom % 8) : IW'($urandom);
                     buf_ext[b] = $urandom % 2;
                  end
                  cmd_ready[b] = 1'b1;
               end
            end
            case ($urandom % 6)
               0: eng_ok = 1;
               1: eng_arb_lost = 1;
               2: eng_err = 1;
               3: begin eng_ok = 1; eng_err = 1; end
               default: ;
            endcase
            step("R2 R3 R4 R5 R6 R8 R9 random");
         end
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule